// File: doc/BRIEF.md
# Time-Triggered Transmit Gate Scheduler

This block decides, for one transmit port, which frame may start on the link in each clock cycle. The port follows a static cyclic schedule. A table of up to `N_SLOTS` offsets, held in ascending order, lists the points within the cluster cycle where time-triggered frames are dispatched. The cycle position comes from the local synchronized time input, which advances by one unit per clock and wraps from `CYCLE_LEN-1` to 0. When the port acts as a synchronization master, it also issues a sync-frame strobe at the start of every cycle.

A pending event-triggered frame is admitted only when it can be sent completely before the next scheduled boundary. The boundary is the next table offset or, when the table is used up, the end of the cycle. A frame already on the link is never cut short: the block tracks link occupancy after every strobe it issues and holds back further releases until the link is free. Frame storage, the MAC and clock correction belong to neighbouring blocks.

The sequencer has three states. `ST_IDLE` means not synchronized. `ST_ALIGN` means synchronized but waiting for the next cycle start. `ST_RUN` means the schedule is executing. The transitions are:
- T_LOCK: `ST_IDLE` to `ST_ALIGN` when the sync flag is seen high.
- T_ALIGN: `ST_ALIGN` to `ST_RUN` at cycle time 0.
- T_LOSE: `ST_ALIGN` or `ST_RUN` back to `ST_IDLE` when the sync flag is low.

Top module: `txg_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tt_dispatch_o`, `sync_frame_o` and `et_release_o` are all 0.
- R2: In `ST_RUN`, one clock after the time input equals the offset of the current table entry (offsets strictly ascending, each in 1..CYCLE_LEN-1; entries 0..count-1 valid, entry k at bits k*TIME_W upward), `tt_dispatch_o` pulses and `tt_slot_o` holds that entry's index k.
- R3: No time-triggered dispatch occurs between the sync flag rising and the first cycle start (time 0) after T_LOCK; T_ALIGN happens at that time 0.
- R4: The entry pointer returns to entry 0 at every cycle start, so the same dispatch pattern repeats in every cycle.
- R5: `sync_frame_o` pulses one clock after time 0 in every cycle, while synchronized in `ST_ALIGN` or `ST_RUN` and only when `sync_master_i` is 1; it never pulses when `sync_master_i` is 0.
- R6: While synchronized, an event-triggered frame of L bytes occupies D = ceil((L+20)*8/BITS_PER_UNIT) units and is released only when D < B - t, where t is the time input and B is the next valid offset, or CYCLE_LEN if none remains.
- R7: The link counts as busy for D units after a release, for SLOT_LEN units after a time-triggered dispatch, and for the duration of a 64-byte frame after a sync-frame strobe; no release is issued while it is busy.
- R8: In the same cycle the sync flag is seen low, dispatching stops; event-triggered frames are then released with no boundary limit, subject only to R7.
- R9: `tt_dispatch_o` and `et_release_o` are never 1 in the same cycle, and every strobe appears exactly one clock after the time value that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_time_i | input | TIME_W | Synchronized position in the cluster cycle |
| synced_i | input | 1 | Node is in a synchronized state |
| sync_master_i | input | 1 | Node acts as synchronization master |
| et_pending_i | input | 1 | An event-triggered frame is waiting |
| et_len_i | input | LEN_W | Length in bytes of the waiting frame |
| tab_count_i | input | CNT_W | Number of valid table entries |
| tab_offs_i | input | N_SLOTS*TIME_W | Packed table of dispatch offsets |
| tt_dispatch_o | output | 1 | Time-triggered dispatch strobe |
| tt_slot_o | output | IDX_W | Table index of the last dispatch |
| sync_frame_o | output | 1 | Sync-frame dispatch strobe |
| et_release_o | output | 1 | Event-triggered release strobe |

## Verification
The bench builds the block with a 400-unit cycle, 20-unit slots and 100 bits per unit. At these values a 210-byte frame lasts 19 units, a 230-byte frame lasts 20 units and a sync frame lasts 7 units. These durations put the strict fit comparison, the slot hold after a dispatch and the end-of-cycle boundary exactly on cycles the bench can name. The short cycle allows several wraps of a three-entry table in a few thousand clocks. It also allows a mid-cycle sync loss and an alignment that starts from the middle of a cycle.

// File: rtl/txg_pkg.sv
package txg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_RUN   = 2'd2
    } txg_state_e;

    // preamble plus inter-frame gap, in bytes
    localparam int WIRE_OVERHEAD_BYTES = 20;
    // size of the integration/sync frame, in bytes
    localparam int SYNC_FRAME_BYTES = 64;
endpackage

// File: rtl/txg_seq.sv
module txg_seq
    import txg_pkg::*;
#(
    parameter int N_SLOTS   = 16,
    parameter int TIME_W    = 16,
    parameter int CYCLE_LEN = 10000,
    localparam int IDX_W    = $clog2(N_SLOTS),
    localparam int CNT_W    = $clog2(N_SLOTS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [TIME_W-1:0]         cyc_time_i,
    input  logic                      synced_i,
    input  logic                      sync_master_i,
    input  logic [CNT_W-1:0]          tab_count_i,
    input  logic [N_SLOTS*TIME_W-1:0] tab_offs_i,
    output logic                      tt_fire_o,
    output logic                      pcf_fire_o,
    output logic [IDX_W-1:0]          slot_o,
    output logic [TIME_W-1:0]         next_off_o,
    output logic                      gated_o
);
    logic [TIME_W-1:0] offs [N_SLOTS];
    txg_state_e        st, st_nx;
    logic [CNT_W-1:0]  ptr;
    logic              at_start;
    logic              have_entry;

    for (genvar k = 0; k < N_SLOTS; k++) begin : g_unpack
        assign offs[k] = tab_offs_i[k*TIME_W +: TIME_W];
    end

    assign at_start   = (cyc_time_i == '0);
    assign have_entry = (ptr < tab_count_i);
    assign slot_o     = ptr[IDX_W-1:0];

    // next-state decode: T_LOCK, T_ALIGN, T_LOSE
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (synced_i) st_nx = ST_ALIGN;
            ST_ALIGN: begin
                if (!synced_i)     st_nx = ST_IDLE;
                else if (at_start) st_nx = ST_RUN;
            end
            ST_RUN:   if (!synced_i) st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // state register and entry pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            ptr <= '0;
        end else begin
            st <= st_nx;
            if (at_start)       ptr <= '0;
            else if (tt_fire_o) ptr <= ptr + CNT_W'(1);
        end
    end

    // per-state outputs
    always_comb begin
        tt_fire_o  = 1'b0;
        pcf_fire_o = 1'b0;
        gated_o    = 1'b0;
        next_off_o = TIME_W'(CYCLE_LEN);
        unique case (st)
            ST_IDLE: ;
            ST_ALIGN: begin
                gated_o    = synced_i;
                pcf_fire_o = synced_i && sync_master_i && at_start;
            end
            ST_RUN: begin
                gated_o    = synced_i;
                pcf_fire_o = synced_i && sync_master_i && at_start;
                tt_fire_o  = synced_i && have_entry && (cyc_time_i == offs[slot_o]);
                if (have_entry) next_off_o = offs[slot_o];
            end
            default: ;
        endcase
    end

    // R3: running state is only ever entered from a cycle start
    p_align_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && $past(st) != ST_RUN) |-> ($past(cyc_time_i) == '0));
endmodule

// File: rtl/txg_admit.sv
module txg_admit
    import txg_pkg::*;
#(
    parameter int LEN_W         = 11,
    parameter int TIME_W        = 16,
    parameter int BITS_PER_UNIT = 100,
    parameter int SLOT_LEN      = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              et_pending_i,
    input  logic [LEN_W-1:0]  et_len_i,
    input  logic [TIME_W-1:0] cyc_time_i,
    input  logic [TIME_W-1:0] next_off_i,
    input  logic              gated_i,
    input  logic              tt_fire_i,
    input  logic              pcf_fire_i,
    output logic              et_go_o
);
    localparam int SYNC_UNITS =
        ((SYNC_FRAME_BYTES + WIRE_OVERHEAD_BYTES) * 8 + BITS_PER_UNIT - 1) / BITS_PER_UNIT;

    logic [31:0] dur, gap, busy;
    logic        fits;

    assign dur  = ((32'(et_len_i) + 32'(WIRE_OVERHEAD_BYTES)) * 32'd8
                   + 32'(BITS_PER_UNIT) - 32'd1) / 32'(BITS_PER_UNIT);
    assign gap  = 32'(next_off_i) - 32'(cyc_time_i);
    assign fits = !gated_i || (dur < gap);

    assign et_go_o = et_pending_i && (busy == '0) && !tt_fire_i && !pcf_fire_i && fits;

    always_ff @(posedge clk) begin
        if (!rst_n)              busy <= '0;
        else if (tt_fire_i)      busy <= 32'(SLOT_LEN);
        else if (pcf_fire_i)     busy <= 32'(SYNC_UNITS);
        else if (et_go_o)        busy <= dur;
        else if (busy != '0)     busy <= busy - 32'd1;
    end

    // R7: a release occupies the link, so none follows directly
    p_no_stack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        et_go_o |=> !et_go_o);
endmodule

// File: rtl/txg_sched.sv
module txg_sched
    import txg_pkg::*;
#(
    parameter int N_SLOTS       = 16,
    parameter int TIME_W        = 16,
    parameter int LEN_W         = 11,
    parameter int CYCLE_LEN     = 10000,
    parameter int SLOT_LEN      = 200,
    parameter int BITS_PER_UNIT = 100,
    localparam int IDX_W        = $clog2(N_SLOTS),
    localparam int CNT_W        = $clog2(N_SLOTS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [TIME_W-1:0]         cyc_time_i,
    input  logic                      synced_i,
    input  logic                      sync_master_i,
    input  logic                      et_pending_i,
    input  logic [LEN_W-1:0]          et_len_i,
    input  logic [CNT_W-1:0]          tab_count_i,
    input  logic [N_SLOTS*TIME_W-1:0] tab_offs_i,
    output logic                      tt_dispatch_o,
    output logic [IDX_W-1:0]          tt_slot_o,
    output logic                      sync_frame_o,
    output logic                      et_release_o
);
    logic              tt_fire, pcf_fire, gated, et_go;
    logic [IDX_W-1:0]  slot;
    logic [TIME_W-1:0] next_off;

    txg_seq #(
        .N_SLOTS(N_SLOTS), .TIME_W(TIME_W), .CYCLE_LEN(CYCLE_LEN)
    ) i_seq (
        .clk(clk), .rst_n(rst_n), .cyc_time_i(cyc_time_i),
        .synced_i(synced_i), .sync_master_i(sync_master_i),
        .tab_count_i(tab_count_i), .tab_offs_i(tab_offs_i),
        .tt_fire_o(tt_fire), .pcf_fire_o(pcf_fire), .slot_o(slot),
        .next_off_o(next_off), .gated_o(gated)
    );

    txg_admit #(
        .LEN_W(LEN_W), .TIME_W(TIME_W),
        .BITS_PER_UNIT(BITS_PER_UNIT), .SLOT_LEN(SLOT_LEN)
    ) i_admit (
        .clk(clk), .rst_n(rst_n), .et_pending_i(et_pending_i),
        .et_len_i(et_len_i), .cyc_time_i(cyc_time_i),
        .next_off_i(next_off), .gated_i(gated),
        .tt_fire_i(tt_fire), .pcf_fire_i(pcf_fire), .et_go_o(et_go)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tt_dispatch_o <= 1'b0;
            tt_slot_o     <= '0;
            sync_frame_o  <= 1'b0;
            et_release_o  <= 1'b0;
        end else begin
            tt_dispatch_o <= tt_fire;
            if (tt_fire) tt_slot_o <= slot;
            sync_frame_o  <= pcf_fire;
            et_release_o  <= et_go;
        end
    end

    // R9: dispatch and release are exclusive
    p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(tt_dispatch_o && et_release_o));
    // R8: sync seen low means no dispatch on the next edge
    p_unsync_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !synced_i |=> !tt_dispatch_o);
    // R5: sync frame only follows a cycle start
    p_sync_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_frame_o |-> ($past(cyc_time_i) == '0));
    // R5: sync frame only for a master
    p_sync_master_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_frame_o |-> $past(sync_master_i));
endmodule

// File: tb/test_txg_sched.sv
`timescale 1ns/1ps
module test_txg_sched;
    localparam int N  = 16;
    localparam int TW = 16;
    localparam int LW = 11;
    localparam int CYC = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [TW-1:0] cyc_time;
    logic synced = 1'b0, master = 1'b0, pend = 1'b0;
    logic [LW-1:0] len = '0;
    logic [4:0] count;
    logic [N*TW-1:0] offs;
    logic tt_d, sf, rel;
    logic [3:0] slot;

    int tm = 0, prev_t = 0;
    int errs = 0, checks = 0;
    int tt_cnt = 0, rel_cnt = 0, sf_cnt = 0;
    bit both_seen = 0, done = 0;

    always #4 clk = ~clk;
    assign cyc_time = TW'(tm);

    txg_sched #(.N_SLOTS(N), .TIME_W(TW), .LEN_W(LW), .CYCLE_LEN(CYC),
                .SLOT_LEN(20), .BITS_PER_UNIT(100)) i_txg_sched (
        .clk(clk), .rst_n(rst_n), .cyc_time_i(cyc_time), .synced_i(synced),
        .sync_master_i(master), .et_pending_i(pend), .et_len_i(len),
        .tab_count_i(count), .tab_offs_i(offs), .tt_dispatch_o(tt_d),
        .tt_slot_o(slot), .sync_frame_o(sf), .et_release_o(rel));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
        prev_t = tm;
        tm = (tm + 1) % CYC;
        if (tt_d && rel) both_seen = 1;
        tt_cnt += int'(tt_d); rel_cnt += int'(rel); sf_cnt += int'(sf);
    endtask

    task automatic run_to(input int t);
        while (tm != t) tick();
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1 chk(!tt_d && !sf && !rel, "R1 during reset", int'({tt_d, sf, rel}), 0);
        rst_n = 1'b1;
        tick();
        chk(!tt_d && !sf && !rel, "R1 after reset", int'({tt_d, sf, rel}), 0);
    endtask

    task automatic t_unsynced();
        run_to(40);
        pend = 1'b1; len = LW'(1500);
        tick();
        chk(rel == 1'b1, "R8 unsynced release ignores boundary", int'(rel), 1);
        pend = 1'b0;
        tt_cnt = 0;
        run_to(310);
        chk(tt_cnt == 0, "R8 no dispatch while unsynced", tt_cnt, 0);
    endtask

    task automatic t_align();
        int pre = 0, mism = 0, s0 = 0, sfm = 0;
        bit seen0 = 0;
        master = 1'b1;
        run_to(40);
        synced = 1'b1;
        sf_cnt = 0;
        for (int i = 0; i < 1200; i++) begin
            bit e_tt;
            int e_slot;
            tick();
            if (prev_t == 0) seen0 = 1;
            e_tt   = seen0 && (prev_t == 50 || prev_t == 120 || prev_t == 300);
            e_slot = (prev_t == 50) ? 0 : (prev_t == 120) ? 1 : 2;
            if (!seen0 && tt_d) pre++;
            if (tt_d != e_tt || (e_tt && int'(slot) != e_slot)) mism++;
            if (tt_d && slot == 4'd0) s0++;
            if (sf != (prev_t == 0)) sfm++;
        end
        chk(pre == 0, "R3 no dispatch before cycle start", pre, 0);
        chk(mism == 0, "R2 dispatch times and slot indices", mism, 0);
        chk(s0 == 2, "R4 pointer wraps, slot 0 once per cycle", s0, 2);
        chk(sfm == 0 && sf_cnt == 3, "R5 sync frame at each cycle start", sf_cnt, 3);
    endtask

    task automatic t_nonmaster();
        master = 1'b0;
        run_to(0);
        sf_cnt = 0; tt_cnt = 0;
        tick();
        run_to(0);
        chk(sf_cnt == 0, "R5 no sync frame when not master", sf_cnt, 0);
        chk(tt_cnt == 3, "R2 dispatches continue without master role", tt_cnt, 3);
        master = 1'b1;
    endtask

    task automatic t_gap();
        int first = -1;
        run_to(100);
        pend = 1'b1; len = LW'(230);
        tick();
        chk(rel == 1'b0, "R6 20-unit frame refused with gap 20", int'(rel), 0);
        for (int i = 0; i < 100 && first < 0; i++) begin
            tick();
            if (rel) first = prev_t;
        end
        pend = 1'b0;
        chk(first == 141, "R7 held through slot occupancy", first, 141);
        run_to(100);
        pend = 1'b1; len = LW'(210);
        tick();
        chk(rel == 1'b1, "R6 19-unit frame admitted with gap 20", int'(rel), 1);
        pend = 1'b0;
        run_to(381);
        pend = 1'b1; len = LW'(210);
        first = -1;
        for (int i = 0; i < 60 && first < 0; i++) begin
            tick();
            if (rel) first = prev_t;
        end
        pend = 1'b0;
        chk(first == 8, "R6 R7 cycle end boundary then sync frame hold", first, 8);
    endtask

    task automatic t_drop();
        run_to(110);
        synced = 1'b0;
        tt_cnt = 0;
        run_to(250);
        pend = 1'b1; len = LW'(1500);
        tick();
        chk(rel == 1'b1, "R8 release without boundary after sync loss", int'(rel), 1);
        pend = 1'b0;
        run_to(310);
        chk(tt_cnt == 0, "R8 dispatch stops mid-cycle", tt_cnt, 0);
        chk(both_seen == 0, "R9 dispatch and release never together", int'(both_seen), 0);
    endtask

    initial begin
        count = 5'd3;
        offs = '0;
        offs[0*TW +: TW] = TW'(50);
        offs[1*TW +: TW] = TW'(120);
        offs[2*TW +: TW] = TW'(300);
        t_reset();
        t_unsynced();
        t_align();
        t_nonmaster();
        t_gap();
        t_drop();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            checks++; errs++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule